// File: doc/BRIEF.md
# External Data Move Stretch Controller

This block runs the bus cycles for data-memory moves issued by a fast 8-bit core that uses four oscillator clocks per machine cycle. A move request carries an address, a direction and write data. The block decides whether the move falls inside a 1 kB internal SRAM window at the bottom of the data space or goes out on the external bus. It then steps through the access and raises a one-clock completion pulse, with read data valid on that pulse.

External moves drive an address-latch pulse (ALE) first, followed by an active-low read or write strobe. A software stretch value sets how many machine cycles long that strobe is. Internal SRAM hits always finish in the minimum time, whatever the stretch value. An emission-reduction control can hold ALE quiet during internal moves, but it never suppresses ALE for an external move. The configuration register (stretch, window enable, ALE quiet) is loaded through a single write port. Requests are taken only while the block is idle.

Top module: `xms_stretch_ctrl`

## Requirements
- R1: After reset, the stretch value is 1, the SRAM window is off, ALE quiet is off, ALE and done are low, and rd_n and wr_n are high.
- R2: While the SRAM window is off, every address from 0x0000 to 0xFFFF is handled as an external move.
- R3: While the window is on, addresses below 0x0400 are internal. They produce no rd_n or wr_n strobe and take 8 clocks for every stretch value.
- R4: An external move with stretch s (0 to 7) takes 8 + 4*s clocks. The first of these clocks is the one after the accepting edge, and done is high in the last one.
- R5: An external move holds rd_n (read, req_we=0) or wr_n (write, req_we=1) low for 4 + 4*s consecutive clocks, starting in its third clock. The two strobes are never low together.
- R6: Every external move has ALE high for exactly its first two clocks. ext_addr carries the move's address throughout those two clocks, and this holds regardless of ALE quiet.
- R7: For internal moves, ALE is high for the first two clocks when ALE quiet is off, and stays low for the whole move when it is on.
- R8: done is a one-clock pulse at the end of every move. rdata on that pulse holds ext_rdata as sampled in the last strobe clock (external reads), or the stored byte (internal reads).
- R9: ext_wdata equals req_wdata while wr_n is low. Internal writes are stored and returned by later internal reads of the same address.
- R10: A request raised while busy is ignored. A configuration write made during a move does not change that move's length or strobe width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the configuration register |
| cfg_stretch | input | 3 | Stretch value to load |
| cfg_sram_en | input | 1 | SRAM window enable to load |
| cfg_ale_off | input | 1 | ALE quiet control to load |
| req | input | 1 | Move request, taken while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Move address |
| req_wdata | input | 8 | Move write data |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read data, valid with done |
| ale | output | 1 | Address latch pulse |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write data |
| ext_rdata | input | 8 | External bus read data |
| rd_n | output | 1 | External read strobe, active low |
| wr_n | output | 1 | External write strobe, active low |

## Verification
The bench aims at the window boundary: addresses 0x03FF and 0x0400, with the window both on and off. A decode off by one there would strobe the bus for an SRAM hit, or the reverse. It sweeps stretch 0 and 7 so that a wrong multiplier, or a miscounted end of strobe, shows up as a wrong clock count. It also checks that ALE quiet never silences an external move, and that a stretch rewrite or a stray request in the middle of a move changes nothing. A design that sampled its configuration live would stretch or shorten that move, and one that accepted the stray request would start a second bus cycle.

// File: rtl/xms_pkg.sv
package xms_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int STRETCH_W  = 3;
    localparam int SRAM_AW    = 10;
    localparam int CLK_PER_MC = 4;
    localparam int BASE_MC    = 2;
    localparam int ALE_CLKS   = CLK_PER_MC / 2;
    localparam int MAX_LEN    = (BASE_MC + (1 << STRETCH_W) - 1) * CLK_PER_MC;
    localparam int CNT_W      = $clog2(MAX_LEN + 1);

    typedef struct packed {
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } xms_req_t;

    typedef struct packed {
        logic [STRETCH_W-1:0] stretch;
        logic                 sram_en;
        logic                 ale_off;
    } xms_cfg_t;

    typedef enum logic {S_IDLE, S_RUN} xms_state_e;

    function automatic logic [CNT_W-1:0] xms_len(input logic [STRETCH_W-1:0] s);
        return CNT_W'(BASE_MC * CLK_PER_MC) + CNT_W'(s) * CNT_W'(CLK_PER_MC);
    endfunction
endpackage

// File: rtl/xms_cfg.sv
module xms_cfg
    import xms_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [STRETCH_W-1:0] stretch_in,
    input  logic                 sram_en_in,
    input  logic                 ale_off_in,
    output xms_cfg_t             cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.stretch <= STRETCH_W'(1);
            cfg.sram_en <= 1'b0;
            cfg.ale_off <= 1'b0;
        end else if (we) begin
            cfg.stretch <= stretch_in;
            cfg.sram_en <= sram_en_in;
            cfg.ale_off <= ale_off_in;
        end
    end
endmodule

// File: rtl/xms_decode.sv
module xms_decode
    import xms_pkg::*;
(
    input  logic              sram_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb hit = sram_en && (addr[ADDR_W-1:SRAM_AW] == '0);
endmodule

// File: rtl/xms_sram.sv
module xms_sram
    import xms_pkg::*;
#(
    parameter int AW = SRAM_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)            q <= '0;
        else if (en && !we) q <= mem[addr];
    end
endmodule

// File: rtl/xms_seq.sv
module xms_seq
    import xms_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  xms_cfg_t          cfg,
    input  logic              req,
    input  xms_req_t          req_in,
    input  logic              hit,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic [DATA_W-1:0] sram_q,
    output logic              sram_en,
    output xms_req_t          cur,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n
);
    xms_state_e           state;
    logic [CNT_W-1:0]     cnt;
    logic                 ext;
    logic                 quiet;
    logic [STRETCH_W-1:0] s_q;
    logic [DATA_W-1:0]    ext_q;
    logic [CNT_W-1:0]     len;
    logic                 strobe_on;
    logic                 run;

    always_comb begin
        run       = (state == S_RUN);
        len       = ext ? xms_len(s_q) : xms_len('0);
        strobe_on = run && ext && (cnt >= CNT_W'(ALE_CLKS)) && (cnt <= len - CNT_W'(3));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
            cur   <= '0;
            ext   <= 1'b0;
            quiet <= 1'b0;
            s_q   <= '0;
            ext_q <= '0;
        end else if (state == S_IDLE) begin
            if (req) begin
                state <= S_RUN;
                cnt   <= '0;
                cur   <= req_in;
                ext   <= !hit;
                quiet <= cfg.ale_off;
                s_q   <= cfg.stretch;
            end
        end else begin
            if (cnt == len - CNT_W'(1)) begin
                state <= S_IDLE;
                cnt   <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
            if (strobe_on && !cur.we && cnt == len - CNT_W'(3)) ext_q <= ext_rdata;
        end
    end

    always_comb begin
        busy    = run;
        done    = run && (cnt == len - CNT_W'(1));
        ale     = run && (cnt < CNT_W'(ALE_CLKS)) && (ext || !quiet);
        rd_n    = !(strobe_on && !cur.we);
        wr_n    = !(strobe_on && cur.we);
        sram_en = run && !ext && (cnt == CNT_W'(ALE_CLKS));
        rdata   = ext ? ext_q : sram_q;
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R6
    ale_before_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(ale));
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_n && wr_n && !done && !ale && !busy));
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(done)) |-> $stable(cur));
endmodule

// File: rtl/xms_stretch_ctrl.sv
module xms_stretch_ctrl
    import xms_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [STRETCH_W-1:0] cfg_stretch,
    input  logic                 cfg_sram_en,
    input  logic                 cfg_ale_off,
    input  logic                 req,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic                 ale,
    output logic [ADDR_W-1:0]    ext_addr,
    output logic [DATA_W-1:0]    ext_wdata,
    input  logic [DATA_W-1:0]    ext_rdata,
    output logic                 rd_n,
    output logic                 wr_n
);
    xms_cfg_t          cfg;
    xms_req_t          req_in;
    xms_req_t          cur;
    logic              hit;
    logic              sram_en;
    logic [DATA_W-1:0] sram_q;

    always_comb begin
        req_in.we    = req_we;
        req_in.addr  = req_addr;
        req_in.wdata = req_wdata;
        ext_addr     = cur.addr;
        ext_wdata    = cur.wdata;
    end

    xms_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .stretch_in(cfg_stretch),
        .sram_en_in(cfg_sram_en), .ale_off_in(cfg_ale_off), .cfg(cfg)
    );

    xms_decode u_dec (.sram_en(cfg.sram_en), .addr(req_addr), .hit(hit));

    xms_sram #(.AW(SRAM_AW), .DW(DATA_W)) u_sram (
        .clk(clk), .rst(rst), .en(sram_en), .we(cur.we),
        .addr(cur.addr[SRAM_AW-1:0]), .wdata(cur.wdata), .q(sram_q)
    );

    xms_seq u_seq (
        .clk(clk), .rst(rst), .cfg(cfg), .req(req), .req_in(req_in), .hit(hit),
        .ext_rdata(ext_rdata), .sram_q(sram_q), .sram_en(sram_en), .cur(cur),
        .busy(busy), .done(done), .rdata(rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );
endmodule

// File: tb/xms_stretch_ctrl_tb_top.sv
module xms_stretch_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_stretch = '0;
    logic cfg_sram_en = 1'b0;
    logic cfg_ale_off = 1'b0;
    logic req = 1'b0;
    logic req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic busy, done, ale, rd_n, wr_n;
    logic [7:0] rdata, ext_wdata, ext_rdata;
    logic [15:0] ext_addr;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [2:0] m_str;
    logic m_en, m_quiet;
    logic [7:0] shadow [1024];
    logic valid [1024];

    always #5 clk = ~clk;

    assign ext_rdata = ext_addr[7:0] ^ ext_addr[15:8] ^ 8'hA5;

    xms_stretch_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_stretch(cfg_stretch),
        .cfg_sram_en(cfg_sram_en), .cfg_ale_off(cfg_ale_off), .req(req),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .ale(ale), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .rd_n(rd_n), .wr_n(wr_n)
    );

    function automatic logic [7:0] ext_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            summary();
        end
    end

    task automatic set_cfg(input logic [2:0] s, input logic en, input logic q);
        @(negedge clk);
        cfg_we = 1'b1; cfg_stretch = s; cfg_sram_en = en; cfg_ale_off = q;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        m_str = s; m_en = en; m_quiet = q;
    endtask

    // inject: mid-move stretch rewrite and stray request (R10)
    task automatic move(input logic we, input logic [15:0] a, input logic [7:0] d, input bit inject);
        bit internal;
        int n, n_ale, n_rd, n_wr, exp_len;
        logic [15:0] ale_addr;
        bit ale_addr_ok, wd_ok;
        logic [7:0] got;
        logic [2:0] s_used;
        internal = m_en && (a < 16'h0400);
        s_used = m_str;
        n = 0; n_ale = 0; n_rd = 0; n_wr = 0; ale_addr_ok = 1; wd_ok = 1; got = '0;
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(posedge clk);
        forever begin
            @(negedge clk);
            req = 1'b0;
            cfg_we = 1'b0;
            n++;
            if (ale) begin n_ale++; if (ext_addr != a) ale_addr_ok = 0; end
            if (!rd_n) n_rd++;
            if (!wr_n) begin n_wr++; if (ext_wdata != d) wd_ok = 0; end
            if (inject && n == 3) begin
                cfg_we = 1'b1; cfg_stretch = 3'd0; cfg_sram_en = m_en; cfg_ale_off = m_quiet;
                req = 1'b1; req_we = 1'b0; req_addr = 16'h8888;
            end
            if (done) begin got = rdata; break; end
            if (n > 64) break;
        end
        if (inject) m_str = 3'd0;
        exp_len = internal ? 8 : 8 + 4 * s_used;
        chk(n == exp_len, internal ? "R3 length" : "R4 length", n, exp_len);
        chk(n_rd == ((!internal && !we) ? exp_len - 4 : 0), internal ? "R3 rd strobe" : "R5 rd width",
            n_rd, (!internal && !we) ? exp_len - 4 : 0);
        chk(n_wr == ((!internal && we) ? exp_len - 4 : 0), internal ? "R3 wr strobe" : "R5 wr width",
            n_wr, (!internal && we) ? exp_len - 4 : 0);
        if (internal)
            chk(n_ale == (m_quiet ? 0 : 2), "R7 ale internal", n_ale, m_quiet ? 0 : 2);
        else begin
            chk(n_ale == 2, "R6 ale external", n_ale, 2);
            chk(ale_addr_ok, "R6 address at ale", ale_addr_ok, 1);
        end
        if (!internal && we) chk(wd_ok, "R9 ext write data", wd_ok, 1);
        if (!we && !internal) chk(got == ext_val(a), "R8 ext read data", got, ext_val(a));
        if (internal && we) begin shadow[a[9:0]] = d; valid[a[9:0]] = 1; end
        if (internal && !we && valid[a[9:0]])
            chk(got == shadow[a[9:0]], "R9 sram readback", got, shadow[a[9:0]]);
        @(negedge clk);
        chk(!done, "R8 done single pulse", done, 0);
        if (inject) begin
            int extra;
            extra = 0;
            repeat (12) begin
                @(negedge clk);
                if (ale || !rd_n || busy) extra++;
            end
            chk(extra == 0, "R10 stray request ignored", extra, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) valid[i] = 0;
        m_str = 3'd1; m_en = 1'b0; m_quiet = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!ale && rd_n && wr_n && !done && !busy, "R1 reset outputs",
            {ale, rd_n, wr_n, done, busy}, 5'b01100);
        // R1 default stretch 1 and window off: low address read goes external, 12 clocks
        move(1'b0, 16'h0010, 8'h00, 0);
        // R2 window off: whole range external
        move(1'b1, 16'h03FF, 8'h3C, 0);
        move(1'b0, 16'hFFFF, 8'h00, 0);
        // R3 window boundary, stretch 7
        set_cfg(3'd7, 1'b1, 1'b0);
        move(1'b1, 16'h03FF, 8'h5E, 0);
        move(1'b0, 16'h03FF, 8'h00, 0);
        move(1'b0, 16'h0400, 8'h00, 0);
        // R4 stretch 0 minimum
        set_cfg(3'd0, 1'b1, 1'b1);
        move(1'b1, 16'h1234, 8'hC3, 0);
        // R7 ALE quiet on internal, R6 still pulses externally
        move(1'b0, 16'h0000, 8'h00, 0);
        move(1'b0, 16'h4000, 8'h00, 0);
        // R10 mid-move rewrite and stray request
        set_cfg(3'd2, 1'b0, 1'b0);
        move(1'b0, 16'h2222, 8'h00, 1);
        // random mix
        void'($urandom(32'd1234));
        for (int k = 0; k < 120; k++) begin
            logic [15:0] a;
            if (k % 10 == 0)
                set_cfg(3'($urandom_range(7)), 1'($urandom_range(1)), 1'($urandom_range(1)));
            a = ($urandom_range(1) == 1) ? 16'($urandom_range(1023)) : 16'($urandom);
            if ($urandom_range(3) == 0) a = 16'($urandom_range(8)) + 16'h03FC;
            move(1'($urandom_range(1)), a, 8'($urandom), 0);
        end
        summary();
    end
endmodule